// File: doc/BRIEF.md
# Hardware Trap Arbitration Unit

This unit gathers run-time exception pulses from a processor core and turns the most urgent one into a non-maskable trap request. For each request it gives the core a vector address and a trap number. The vector address is a programmable segment followed by an offset equal to four times the trap number. Every hardware condition also sets its own sticky bit in a flag register. Software clears that register by writing ones.

Traps run at three fixed levels: reset sources highest, then class A (NMI, stack overflow, stack underflow, software break), then class B. The four class B faults (undefined opcode, memory access error, protected instruction fault, illegal word operand) share one vector but keep separate flags. A pending trap pre-empts a service only when its level is strictly higher than the level now in service. Otherwise it waits until a service-done signal unwinds the nesting. A software trap instruction can pick any of 128 numbers and runs at the level already in service.

Top module: `trap_arbiter`

## Requirements
- R1: Condition bits 0, 1 and 2 (hardware reset, software reset, watchdog overflow) produce trap number 0x00 at level 3. If several arrive in one cycle, one trap is taken for all of them.
- R2: Condition bits 3, 4, 5 and 6 (NMI, stack overflow, stack underflow, software break) produce trap numbers 0x02, 0x04, 0x06 and 0x08, each at level 2.
- R3: Condition bits 7 to 10 (undefined opcode, memory access error, protected instruction fault, illegal word operand) all produce trap number 0x0A at level 1. Any mix of them arriving together is served by a single trap.
- R4: A trap is signalled by trap_req_o high for one cycle. This happens in the cycle after the clock edge that accepts it. vec_addr_o then holds vec_seg_i in its upper bits and trap number times 4 in its lower 16 bits. svc_prio_o (0 meaning no trap service) shows the new level.
- R5: Each condition pulse sets flags_o bit equal to its condition index. Flag bits stay set until the same bit is written as one on flag_clr_i. A set and a clear of the same bit in the same cycle leave the bit set.
- R6: A pending hardware trap is taken only when its level is strictly above svc_prio_o. A trap at an equal or lower level stays pending and is taken once the level has dropped below it.
- R7: Among conditions pending together, the order is: reset group, NMI, stack overflow, stack underflow, software break, class B. The others are served one at a time afterwards, while all their flags are set at once.
- R8: svc_done_i restores the level that was in service before the most recent trap. When no trap is in service it has no effect. No trap is taken in a cycle in which svc_done_i is high.
- R9: A software trap request (sw_req_i with a 7-bit number 0x00 to 0x7F) produces that number and the offset number times 4. It leaves svc_prio_o unchanged. A hardware trap taken in the same cycle goes first.
- R10: Clearing a flag does not cancel or alter a trap already taken. svc_prio_o is unchanged by the clear.
- R11: Hardware conditions never produce trap numbers 0x0B to 0x0F or any number other than 0x00, 0x02, 0x04, 0x06, 0x08 and 0x0A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cond_i | input | 11 | One-cycle exception condition pulses, index as in R1 to R3 |
| flag_clr_i | input | 11 | Write-one-to-clear strobes for the flag bits |
| sw_req_i | input | 1 | Software trap request |
| sw_num_i | input | 7 | Software trap number |
| vec_seg_i | input | SEG_W | Vector segment |
| svc_done_i | input | 1 | Current trap service finished |
| trap_req_o | output | 1 | Trap request pulse to the core |
| vec_addr_o | output | SEG_W+LOW_W | Vector address of the last trap taken |
| trap_num_o | output | 7 | Trap number of the last trap taken |
| svc_prio_o | output | 2 | Trap level in service (0 none, 1 to 3) |
| flags_o | output | 11 | Sticky trap flags |

## Verification
The hardest case to reach is a condition that arrives while a service at its own or a higher level is in progress. It must stay pending through several unwinds and only then be taken. The bench reaches it by nesting traps on purpose. It raises a class B trap, pre-empts it with NMI, and adds a further class B fault while level 1 is still active. It then steps svc_done_i and checks the restored level and the delayed trap after each step. It also fires all class A conditions at once and checks that they drain in order, one per completed service.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int NCOND = 11;
  localparam int NUM_W = 7;

  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_IDLE = 2'd0;
  localparam lvl_t LVL_B    = 2'd1;
  localparam lvl_t LVL_A    = 2'd2;
  localparam lvl_t LVL_RST  = 2'd3;

  localparam int C_HWRST = 0;
  localparam int C_WDT   = 2;
  localparam int C_NMI   = 3;
  localparam int C_SBRK  = 6;
  localparam int C_BLO   = 7;
  localparam int C_BHI   = 10;

  localparam logic [NUM_W-1:0] NUM_RST = 7'h00;
  localparam logic [NUM_W-1:0] NUM_B   = 7'h0A;

  // class A condition index -> trap number (2, 4, 6, 8)
  function automatic logic [NUM_W-1:0] class_a_num(input int idx);
    return NUM_W'(2 * (idx - C_NMI + 1));
  endfunction

  // trap number -> vector offset
  function automatic logic [NUM_W+1:0] num_to_offset(input logic [NUM_W-1:0] n);
    return {n, 2'b00};
  endfunction
endpackage

// File: rtl/trap_flag_reg.sv
module trap_flag_reg
  import trap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCOND-1:0] set_i,
  input  logic [NCOND-1:0] clr_i,
  output logic [NCOND-1:0] flags_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_o <= '0;
    else        flags_o <= (flags_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/trap_prio_sel.sv
module trap_prio_sel
  import trap_pkg::*;
(
  input  logic [NCOND-1:0] pend_i,
  output logic             any_o,
  output lvl_t             lvl_o,
  output logic [NUM_W-1:0] num_o,
  output logic [NCOND-1:0] grp_o
);
  logic             a_hit;
  logic [NUM_W-1:0] a_num;
  logic [NCOND-1:0] a_grp;
  logic [NCOND-1:0] rst_grp, b_grp;

  always_comb begin
    rst_grp = '0;
    b_grp   = '0;
    for (int i = C_HWRST; i <= C_WDT; i++) rst_grp[i] = 1'b1;
    for (int i = C_BLO; i <= C_BHI; i++)   b_grp[i]   = 1'b1;
  end

  // lowest index among class A wins
  always_comb begin
    a_hit = 1'b0;
    a_num = '0;
    a_grp = '0;
    for (int i = C_SBRK; i >= C_NMI; i--) begin
      if (pend_i[i]) begin
        a_hit = 1'b1;
        a_num = class_a_num(i);
        a_grp = '0;
        a_grp[i] = 1'b1;
      end
    end
  end

  always_comb begin
    any_o = 1'b1;
    lvl_o = LVL_IDLE;
    num_o = '0;
    grp_o = '0;
    if (|(pend_i & rst_grp)) begin
      lvl_o = LVL_RST; num_o = NUM_RST; grp_o = rst_grp;
    end else if (a_hit) begin
      lvl_o = LVL_A;   num_o = a_num;   grp_o = a_grp;
    end else if (|(pend_i & b_grp)) begin
      lvl_o = LVL_B;   num_o = NUM_B;   grp_o = b_grp;
    end else begin
      any_o = 1'b0;
    end
  end
endmodule

// File: rtl/trap_level_stack.sv
module trap_level_stack
  import trap_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int SP_W = $clog2(DEPTH + 1)
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_i,
  input  lvl_t            push_lvl_i,
  input  logic            pop_i,
  output lvl_t            cur_o,
  output logic            full_o,
  output logic [SP_W-1:0] sp_o
);
  lvl_t saved [DEPTH];

  assign full_o = (sp_o == SP_W'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_o <= LVL_IDLE;
      sp_o  <= '0;
    end else if (push_i && !full_o) begin
      cur_o <= push_lvl_i;
      sp_o  <= sp_o + 1'b1;
    end else if (pop_i && sp_o != '0) begin
      cur_o <= saved[sp_o - 1'b1];
      sp_o  <= sp_o - 1'b1;
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) saved[g] <= LVL_IDLE;
        else if (push_i && !full_o && sp_o == SP_W'(g)) saved[g] <= cur_o;
      end
    end
  endgenerate
endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
#(
  parameter int SEG_W = 8,
  parameter int LOW_W = 16,
  parameter int DEPTH = 8,
  localparam int SP_W = $clog2(DEPTH + 1)
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [10:0]            cond_i,
  input  logic [10:0]            flag_clr_i,
  input  logic                   sw_req_i,
  input  logic [6:0]             sw_num_i,
  input  logic [SEG_W-1:0]       vec_seg_i,
  input  logic                   svc_done_i,
  output logic                   trap_req_o,
  output logic [SEG_W+LOW_W-1:0] vec_addr_o,
  output logic [6:0]             trap_num_o,
  output logic [1:0]             svc_prio_o,
  output logic [10:0]            flags_o
);
  logic [NCOND-1:0] pend_q, pend_all, sel_grp;
  logic             sel_any, full;
  lvl_t             sel_lvl, cur_lvl, new_lvl;
  logic [NUM_W-1:0] sel_num, sw_num_q, sw_num, take_num;
  logic             sw_pend_q, sw_all;
  logic             hw_take, sw_take, take;
  logic [SP_W-1:0]  sp;

  assign pend_all = pend_q | cond_i;

  trap_flag_reg u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(cond_i), .clr_i(flag_clr_i), .flags_o(flags_o)
  );

  trap_prio_sel u_sel (
    .pend_i(pend_all), .any_o(sel_any), .lvl_o(sel_lvl), .num_o(sel_num), .grp_o(sel_grp)
  );

  assign sw_all   = sw_req_i | sw_pend_q;
  assign sw_num   = sw_req_i ? sw_num_i : sw_num_q;
  assign hw_take  = sel_any && (sel_lvl > cur_lvl) && !svc_done_i && !full;
  assign sw_take  = sw_all && !hw_take && !svc_done_i && !full;
  assign take     = hw_take | sw_take;
  assign new_lvl  = hw_take ? sel_lvl : cur_lvl;
  assign take_num = hw_take ? sel_num : sw_num;

  trap_level_stack #(.DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .push_i(take), .push_lvl_i(new_lvl),
    .pop_i(svc_done_i), .cur_o(cur_lvl), .full_o(full), .sp_o(sp)
  );

  assign svc_prio_o = cur_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= '0;
      sw_pend_q  <= 1'b0;
      sw_num_q   <= '0;
      trap_req_o <= 1'b0;
      trap_num_o <= '0;
      vec_addr_o <= '0;
    end else begin
      pend_q     <= pend_all & ~(hw_take ? sel_grp : '0);
      sw_pend_q  <= sw_all & !sw_take;
      sw_num_q   <= sw_num;
      trap_req_o <= take;
      if (take) begin
        trap_num_o <= take_num;
        vec_addr_o <= {vec_seg_i, LOW_W'(num_to_offset(take_num))};
      end
    end
  end
endmodule

// File: rtl/trap_arbiter_chk.sv
module trap_arbiter_chk #(
  parameter int SEG_W = 8,
  parameter int LOW_W = 16,
  parameter int DEPTH = 8,
  localparam int SP_W = $clog2(DEPTH + 1)
)(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   hw_take,
  input logic                   sw_take,
  input logic                   svc_done_i,
  input logic [10:0]            cond_i,
  input logic [10:0]            flag_clr_i,
  input logic                   trap_req_o,
  input logic [SEG_W+LOW_W-1:0] vec_addr_o,
  input logic [6:0]             trap_num_o,
  input logic [1:0]             svc_prio_o,
  input logic [10:0]            flags_o,
  input logic [SP_W-1:0]        sp
);
  AST_PREEMPT_HIGHER: assert property (@(posedge clk) disable iff (!rst_n)
    hw_take |=> svc_prio_o > $past(svc_prio_o)); // R6
  AST_VECTOR_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req_o |-> vec_addr_o[LOW_W-1:0] == LOW_W'({trap_num_o, 2'b00})); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (flags_o & $past(flags_o & ~flag_clr_i)) == $past(flags_o & ~flag_clr_i)); // R5
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (flags_o & $past(cond_i)) == $past(cond_i)); // R5
  AST_NO_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    hw_take |=> (trap_num_o inside {7'h00, 7'h02, 7'h04, 7'h06, 7'h08, 7'h0A})); // R11
  AST_DONE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    svc_done_i |=> !trap_req_o); // R8
  AST_SW_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    sw_take |=> $stable(svc_prio_o)); // R9
  AST_STACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SP_W'(DEPTH)); // R8
endmodule

bind trap_arbiter trap_arbiter_chk #(.SEG_W(SEG_W), .LOW_W(LOW_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_take(hw_take), .sw_take(sw_take),
  .svc_done_i(svc_done_i), .cond_i(cond_i), .flag_clr_i(flag_clr_i),
  .trap_req_o(trap_req_o), .vec_addr_o(vec_addr_o), .trap_num_o(trap_num_o),
  .svc_prio_o(svc_prio_o), .flags_o(flags_o), .sp(sp)
);

// File: tb/tb_trap_arbiter.sv
module tb_trap_arbiter;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [10:0] cond_i = '0, flag_clr_i = '0;
  logic        sw_req_i = 0, svc_done_i = 0;
  logic [6:0]  sw_num_i = '0;
  logic [7:0]  vec_seg_i = '0;
  logic        trap_req_o;
  logic [23:0] vec_addr_o;
  logic [6:0]  trap_num_o;
  logic [1:0]  svc_prio_o;
  logic [10:0] flags_o;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  trap_arbiter dut (
    .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .flag_clr_i(flag_clr_i),
    .sw_req_i(sw_req_i), .sw_num_i(sw_num_i), .vec_seg_i(vec_seg_i),
    .svc_done_i(svc_done_i), .trap_req_o(trap_req_o), .vec_addr_o(vec_addr_o),
    .trap_num_o(trap_num_o), .svc_prio_o(svc_prio_o), .flags_o(flags_o)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic pulse(input logic [10:0] c);
    @(negedge clk); cond_i = c;
    @(negedge clk); cond_i = '0;
  endtask

  task automatic done();
    @(negedge clk); svc_done_i = 1;
    @(negedge clk); svc_done_i = 0;
  endtask

  task automatic clear_all();
    @(negedge clk); flag_clr_i = '1;
    @(negedge clk); flag_clr_i = '0;
  endtask

  task automatic sw(input int n);
    @(negedge clk); sw_req_i = 1; sw_num_i = 7'(n);
    @(negedge clk); sw_req_i = 0;
  endtask

  function automatic int exp_lvl(input int c);
    return c < 3 ? 3 : (c < 7 ? 2 : 1);
  endfunction
  function automatic int exp_num(input int c);
    return c < 3 ? 0 : (c < 7 ? 2 * (c - 2) : 10);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R4 reset req", trap_req_o, 0);
    check("R8 reset prio", svc_prio_o, 0);
    check("R5 reset flags", flags_o, 0);

    // R1 R2 R3 single-condition sweep
    for (int c = 0; c < 11; c++) begin
      vec_seg_i = 8'(c * 17 + 3);
      pulse(11'(1 << c));
      check("R4 req", trap_req_o, 1);
      check("R1/R2/R3 num", trap_num_o, exp_num(c));
      check("R4 vector", vec_addr_o, (int'(vec_seg_i) << 16) | (exp_num(c) * 4));
      check("R1/R2/R3 level", svc_prio_o, exp_lvl(c));
      check("R5 flag", flags_o, 1 << c);
      @(negedge clk);
      check("R4 single pulse", trap_req_o, 0);
      done();
      check("R8 restore idle", svc_prio_o, 0);
      clear_all();
      check("R5 w1c all", flags_o, 0);
    end

    // R7 class A ordering
    pulse(11'h078);
    check("R7 first NMI", trap_num_o, 2);
    check("R7 all flags", flags_o, 11'h078);
    for (int k = 1; k < 4; k++) begin
      done();
      check("R6 waits", svc_prio_o, 0);
      @(negedge clk);
      check("R7 next req", trap_req_o, 1);
      check("R7 next num", trap_num_o, 2 * (k + 1));
    end
    done();
    @(negedge clk);
    check("R7 drained", trap_req_o, 0);
    clear_all();

    // R3 shared class B vector, R1 reset group
    pulse(11'h780);
    check("R3 one B num", trap_num_o, 10);
    check("R3 B flags", flags_o, 11'h780);
    done();
    @(negedge clk);
    check("R3 no second B", trap_req_o, 0);
    pulse(11'h007);
    check("R1 group num", trap_num_o, 0);
    done();
    @(negedge clk);
    check("R1 no second reset", trap_req_o, 0);
    clear_all();

    // R6 nesting and R8 unwind
    pulse(11'h080);
    check("R6 B level", svc_prio_o, 1);
    pulse(11'h008);
    check("R6 NMI preempts", trap_req_o, 1);
    check("R6 NMI level", svc_prio_o, 2);
    done();
    check("R8 back to B", svc_prio_o, 1);
    pulse(11'h200);
    check("R6 equal waits", trap_req_o, 0);
    check("R6 level kept", svc_prio_o, 1);
    done();
    check("R8 idle", svc_prio_o, 0);
    @(negedge clk);
    check("R6 delayed B req", trap_req_o, 1);
    check("R6 delayed B num", trap_num_o, 10);
    done();
    pulse(11'h001);
    pulse(11'h004);
    check("R6 reset over reset waits", trap_req_o, 0);
    done();
    @(negedge clk);
    check("R6 second reset", trap_req_o, 1);
    check("R1 level", svc_prio_o, 3);
    done();
    clear_all();

    // R9 software trap sweep
    vec_seg_i = 8'h5A;
    for (int n = 0; n < 128; n++) begin
      sw(n);
      check("R9 req", trap_req_o, 1);
      check("R9 num", trap_num_o, n);
      check("R9 vector", vec_addr_o, (8'h5A << 16) | (n * 4));
      check("R9 level", svc_prio_o, 0);
      done();
    end
    pulse(11'h008);
    sw(7'h45);
    check("R9 inside NMI num", trap_num_o, 7'h45);
    check("R9 inside NMI level", svc_prio_o, 2);
    done();
    check("R8 sw unwind", svc_prio_o, 2);
    done();
    check("R8 nmi unwind", svc_prio_o, 0);
    @(negedge clk); sw_req_i = 1; sw_num_i = 7'h33; cond_i = 11'h020;
    @(negedge clk); sw_req_i = 0; cond_i = '0;
    check("R9 hw first", trap_num_o, 6);
    @(negedge clk);
    check("R9 sw after", trap_num_o, 7'h33);
    check("R9 sw level", svc_prio_o, 2);
    done(); done();
    clear_all();

    // R10 clearing does not cancel, R5 set wins
    pulse(11'h108);
    check("R10 NMI taken", svc_prio_o, 2);
    @(negedge clk); flag_clr_i = 11'h008;
    @(negedge clk); flag_clr_i = '0;
    check("R10 flag cleared", flags_o, 11'h100);
    check("R10 level kept", svc_prio_o, 2);
    @(negedge clk); flag_clr_i = 11'h100; cond_i = 11'h100;
    @(negedge clk); flag_clr_i = '0; cond_i = '0;
    check("R5 set wins", flags_o, 11'h100);
    done();
    @(negedge clk);
    check("R10 B follows", trap_num_o, 10);
    done();
    clear_all();

    // R8 done while idle
    done();
    check("R8 idle done", svc_prio_o, 0);
    @(negedge clk);
    check("R8 idle no req", trap_req_o, 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule